// File: doc/BRIEF.md
# Graphic Window Line Prefetch FIFO with Watermark Requests

This block buffers graphic-window pixel longwords between a DMA master and the pixel pipeline. It holds a 32-deep, 32-bit wide line FIFO. The DMA side pushes returned longwords through `dma_wvalid`/`dma_wdata`. The pixel side pops the oldest entry with `pix_rd` and sees it on `pix_data` in the same cycle. Both levels are visible on `fill_level` and `empty_slots`.

A control word sets the refill policy. When the FIFO runs low (the fill level is at or below the trigger mark), the block raises `dma_req`. It holds that request until the burst is complete. Only one request is outstanding at a time. With the fixed policy, a burst ends after exactly the high mark number of accepted longwords. With the dynamic policy, the burst continues until the free space is at or below the high mark minus two. A control word that breaks the legality rules sets a sticky error and blocks new requests until a legal word is written.

Top module: `gwf_line_fetch`

## Requirements
- R1: The FIFO stores up to 32 longwords and returns them in arrival order; `fill_level` + `empty_slots` always equals 32.
- R2: The control word places the policy bit at bit 31 (1 = fixed, 0 = dynamic), the high mark at bits 20:16 and the trigger mark at bits 4:0; every other bit reads as zero; the reset value is 0x8008_0004 (fixed, high mark 8, trigger mark 4).
- R3: With no burst outstanding and no configuration error, `dma_req` rises at the clock edge after the edge where `fill_level` is at or below the trigger mark, and stays high until its burst ends.
- R4: In fixed mode a burst ends on its high-mark-th accepted write, and `burst_len` shows the high mark.
- R5: In dynamic mode a burst ends on the accepted write that leaves `empty_slots` at or below the high mark minus 2, and `burst_len` reads 0.
- R6: `burst_done` is a one-cycle pulse in the cycle after the final write of a burst, and `dma_req` is low in that cycle.
- R7: A control word is illegal when it selects dynamic with a high mark below 3, or fixed with a high mark not greater than the trigger mark. Writing an illegal word sets `config_error` from the next cycle. The error stays set until a legal word is written. While it is set, no new request is raised.
- R8: A write while the FIFO holds 32 entries is dropped, leaves the contents unchanged and sets the sticky `overflow` flag.
- R9: A read while the FIFO is empty returns zero on `pix_data` and sets the sticky `underflow` flag.
- R10: During reset the FIFO is empty, `dma_req`, `burst_done` and all flags are low, and the control word holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back, reserved bits zero |
| dma_wvalid | input | 1 | A returned longword is presented |
| dma_wdata | input | 32 | Returned longword |
| dma_req | output | 1 | Burst request, high while a burst is outstanding |
| burst_len | output | 6 | Longwords per burst in fixed mode, 0 in dynamic mode |
| burst_done | output | 1 | One-cycle pulse after the final write of a burst |
| pix_rd | input | 1 | Pop the oldest longword |
| pix_data | output | 32 | Oldest longword, zero when empty |
| fill_level | output | 6 | Occupied entries |
| empty_slots | output | 6 | Free entries |
| overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |
| underflow | output | 1 | Sticky: a read hit an empty FIFO |
| config_error | output | 1 | Sticky until rewritten: the control word is illegal |

## Verification
The assertions check, on every cycle, the properties that a single cycle or one cycle of lag can show. These are the level bound and level sum, the reserved bits reading zero, `burst_len` following the policy bit, `dma_req` falling only together with `burst_done`, the done pulse lasting one cycle, a standing error keeping the request low, a full FIFO refusing a write, and the zero returned on an empty read. Other behaviours depend on the whole length of a burst or on the order of the data. These are the exact beat counts at which fixed and dynamic bursts end, the order of data after a dropped write, and the error being cleared by a legal rewrite. Only the directed scenarios show them, because they count beats and compare the data they read back.

// File: rtl/gwf_pkg.sv
package gwf_pkg;
  localparam int MARK_W = 5;
  localparam int CFG_W  = 32;

  typedef struct packed {
    logic              fixed_len;
    logic [MARK_W-1:0] high_mark;
    logic [MARK_W-1:0] trig_mark;
  } gwf_cfg_t;

  localparam gwf_cfg_t CFG_RST = '{fixed_len: 1'b1, high_mark: 5'd8, trig_mark: 5'd4};
  localparam logic [CFG_W-1:0] CFG_RSV_MASK = 32'h7FE0_FFE0;

  function automatic gwf_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    gwf_cfg_t c;
    c.fixed_len = w[31];
    c.high_mark = w[20:16];
    c.trig_mark = w[4:0];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input gwf_cfg_t c);
    logic [CFG_W-1:0] w;
    w        = '0;
    w[31]    = c.fixed_len;
    w[20:16] = c.high_mark;
    w[4:0]   = c.trig_mark;
    return w;
  endfunction

  // fixed: high mark above trigger mark; dynamic: high mark at least 3
  function automatic logic cfg_legal(input gwf_cfg_t c);
    if (c.fixed_len) return c.high_mark > c.trig_mark;
    return c.high_mark >= 5'd3;
  endfunction

  // dynamic stop rule: free space after this cycle at or below high mark - 2
  function automatic logic dyn_reached(input int free_next, input logic [MARK_W-1:0] hm);
    return free_next <= (int'(hm) - 2);
  endfunction

  // fixed stop rule: this accepted write is beat number high mark
  function automatic logic fix_reached(input int beats_before, input logic [MARK_W-1:0] hm);
    return (beats_before + 1) >= int'(hm);
  endfunction
endpackage

// File: rtl/gwf_cfg_reg.sv
module gwf_cfg_reg
  import gwf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output gwf_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             cfg_err
);
  gwf_cfg_t cfg_q;
  logic     err_q;
  gwf_cfg_t cfg_new;

  assign cfg_new = cfg_unpack(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      err_q <= 1'b0;
    end else if (we) begin
      cfg_q <= cfg_new;
      err_q <= !cfg_legal(cfg_new);
    end
  end

  assign cfg     = cfg_q;
  assign rdata   = cfg_pack(cfg_q);
  assign cfg_err = err_q;
endmodule

// File: rtl/gwf_line_fifo.sv
module gwf_line_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     level,
  output logic              wr_acc,
  output logic              rd_acc,
  output logic              ovf,
  output logic              udf
);
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              full, empty;
  logic              ovf_q, udf_q;

  assign full   = (level_q == CW'(DEPTH));
  assign empty  = (level_q == '0);
  assign wr_acc = wr_en && !full;
  assign rd_acc = rd_en && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_acc && (wr_ptr == AW'(g))) mem_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
      level_q <= level_q + CW'(wr_acc) - CW'(rd_acc);
      if (wr_en && full)  ovf_q <= 1'b1;
      if (rd_en && empty) udf_q <= 1'b1;
    end
  end

  assign rd_data = empty ? '0 : mem_q[rd_ptr];
  assign level   = level_q;
  assign ovf     = ovf_q;
  assign udf     = udf_q;
endmodule

// File: rtl/gwf_req_ctrl.sv
module gwf_req_ctrl
  import gwf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gwf_cfg_t      cfg,
  input  logic          cfg_err,
  input  logic [CW-1:0] level,
  input  logic          wr_acc,
  input  logic          rd_acc,
  output logic          req,
  output logic          done,
  output logic          burst_end,
  output logic          raise
);
  logic          active_q, done_q;
  logic [CW-1:0] beats_q;
  logic [CW-1:0] level_next;
  int            free_next;
  logic          stop_hit;

  assign level_next = level + CW'(wr_acc) - CW'(rd_acc);
  assign free_next  = DEPTH - int'(level_next);
  assign stop_hit   = cfg.fixed_len ? fix_reached(int'(beats_q), cfg.high_mark)
                                    : dyn_reached(free_next, cfg.high_mark);
  assign burst_end  = active_q && wr_acc && stop_hit;
  assign raise      = !active_q && !cfg_err && (level <= CW'(cfg.trig_mark));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      beats_q  <= '0;
    end else begin
      done_q <= burst_end;
      if (burst_end) begin
        active_q <= 1'b0;
        beats_q  <= '0;
      end else if (raise) begin
        active_q <= 1'b1;
        beats_q  <= '0;
      end else if (active_q && wr_acc) begin
        beats_q <= beats_q + 1'b1;
      end
    end
  end

  assign req  = active_q;
  assign done = done_q;
endmodule

// File: rtl/gwf_line_fetch.sv
module gwf_line_fetch
  import gwf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dma_wvalid,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_req,
  output logic [CW-1:0]     burst_len,
  output logic              burst_done,
  input  logic              pix_rd,
  output logic [DATA_W-1:0] pix_data,
  output logic [CW-1:0]     fill_level,
  output logic [CW-1:0]     empty_slots,
  output logic              overflow,
  output logic              underflow,
  output logic              config_error
);
  gwf_cfg_t      cfg;
  logic          cfg_err;
  logic [CW-1:0] level;
  logic          wr_acc, rd_acc;
  logic          burst_end, req_raise;

  gwf_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata), .cfg_err(cfg_err)
  );

  gwf_line_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(dma_wvalid), .wr_data(dma_wdata),
    .rd_en(pix_rd), .rd_data(pix_data), .level(level),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .ovf(overflow), .udf(underflow)
  );

  gwf_req_ctrl #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cfg_err(cfg_err), .level(level),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .req(dma_req), .done(burst_done),
    .burst_end(burst_end), .raise(req_raise)
  );

  assign burst_len    = cfg.fixed_len ? CW'(cfg.high_mark) : '0;
  assign fill_level   = level;
  assign empty_slots  = CW'(DEPTH) - level;
  assign config_error = cfg_err;
endmodule

// File: rtl/gwf_checker.sv
module gwf_checker #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [31:0]       cfg_rdata,
  input logic              dma_wvalid,
  input logic              dma_req,
  input logic [CW-1:0]     burst_len,
  input logic              burst_done,
  input logic              pix_rd,
  input logic [DATA_W-1:0] pix_data,
  input logic [CW-1:0]     fill_level,
  input logic [CW-1:0]     empty_slots,
  input logic              overflow,
  input logic              config_error
);
  assert_fill_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level <= CW'(DEPTH)) && (int'(fill_level) + int'(empty_slots) == DEPTH));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 32'h7FE0_FFE0) == 32'h0);

  assert_req_ends_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> burst_done);

  assert_fixed_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31] |-> (burst_len == CW'(cfg_rdata[20:16])));

  assert_dyn_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[31] |-> (burst_len == '0));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  assert_done_req_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> !dma_req);

  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (config_error && !dma_req && !cfg_we) |=> !dma_req);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CW'(DEPTH) && dma_wvalid && !pix_rd) |=> (fill_level == CW'(DEPTH)) && overflow);

  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd && fill_level == '0) |-> (pix_data == '0));
endmodule

bind gwf_line_fetch gwf_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .dma_wvalid(dma_wvalid), .dma_req(dma_req), .burst_len(burst_len),
  .burst_done(burst_done), .pix_rd(pix_rd), .pix_data(pix_data),
  .fill_level(fill_level), .empty_slots(empty_slots), .overflow(overflow),
  .config_error(config_error)
);

// File: tb/gwf_line_fetch_tb.sv
`timescale 1ns/1ps
module gwf_line_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dma_wvalid = 1'b0;
  logic [31:0] dma_wdata = '0;
  logic        dma_req;
  logic [5:0]  burst_len;
  logic        burst_done;
  logic        pix_rd = 1'b0;
  logic [31:0] pix_data;
  logic [5:0]  fill_level, empty_slots;
  logic        overflow, underflow, config_error;

  int  n_chk = 0;
  int  n_pass = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  gwf_line_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dma_wvalid(dma_wvalid), .dma_wdata(dma_wdata),
    .dma_req(dma_req), .burst_len(burst_len), .burst_done(burst_done),
    .pix_rd(pix_rd), .pix_data(pix_data), .fill_level(fill_level),
    .empty_slots(empty_slots), .overflow(overflow), .underflow(underflow),
    .config_error(config_error)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 0; dma_wvalid = 0; pix_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    dma_wvalid = 1'b1; dma_wdata = d;
    @(posedge clk); #1;
    dma_wvalid = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    pix_rd = 1'b1;
    #0.5 d = pix_data;
    @(posedge clk); #1;
    pix_rd = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk_eq("R10 cfg reset value (R2)", cfg_rdata, 32'h8008_0004);
    chk_eq("R10 idle outputs", {dma_req, burst_done, overflow, underflow, config_error}, 5'b0);
    chk_eq("R10 fill empty", {fill_level, empty_slots}, {6'd0, 6'd32});
  endtask

  task automatic t_fixed();
    logic [31:0] d;
    do_reset();
    step();
    chk_eq("R3 request after reset", dma_req, 1'b1);
    chk_eq("R4 burst_len fixed", burst_len, 6'd8);
    for (int i = 0; i < 7; i++) push(32'hA000_0000 + i);
    chk_eq("R4 burst open after 7 beats", {dma_req, burst_done}, 2'b10);
    push(32'hA000_0007);
    chk_eq("R6 done pulse, req low", {dma_req, burst_done}, 2'b01);
    chk_eq("R4 fill after burst", fill_level, 6'd8);
    step();
    chk_eq("R6 done one cycle", {dma_req, burst_done}, 2'b00);
    for (int i = 0; i < 4; i++) begin
      pop(d);
      chk_eq("R1 data order", d, 32'hA000_0000 + i);
    end
    chk_eq("R3 no request at level 4 yet", dma_req, 1'b0);
    step();
    chk_eq("R3 request at trigger mark", dma_req, 1'b1);
  endtask

  task automatic t_dynamic();
    do_reset();
    cfg_write(32'h0006_0002);
    chk_eq("R5 burst_len dynamic", burst_len, 6'd0);
    chk_eq("R3 request outstanding", dma_req, 1'b1);
    for (int i = 0; i < 27; i++) push(32'hB000_0000 + i);
    chk_eq("R5 still open at 5 free", {dma_req, burst_done, empty_slots}, {2'b10, 6'd5});
    push(32'hB000_001B);
    chk_eq("R5 ends at 4 free", {dma_req, burst_done, empty_slots}, {2'b01, 6'd4});
    step();
    chk_eq("R3 no request above trigger", dma_req, 1'b0);
  endtask

  task automatic t_config_error();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < 8; i++) push(32'hC000_0000 + i);
    cfg_write(32'h0002_0001);
    chk_eq("R7 dynamic hm 2 illegal", config_error, 1'b1);
    cfg_write(32'h8004_0004);
    chk_eq("R7 fixed hm equal tm illegal", config_error, 1'b1);
    for (int i = 0; i < 8; i++) pop(d);
    step(); step();
    chk_eq("R7 request suppressed", dma_req, 1'b0);
    pop(d);
    chk_eq("R9 empty read zero", d, 32'h0);
    chk_eq("R9 underflow flag", underflow, 1'b1);
    cfg_write(32'h8008_0004);
    chk_eq("R7 cleared by legal write", config_error, 1'b0);
    step();
    chk_eq("R7 request resumes", dma_req, 1'b1);
  endtask

  task automatic t_register();
    do_reset();
    cfg_write(32'hFFFF_FFFF);
    chk_eq("R2 reserved read zero", cfg_rdata, 32'h801F_001F);
    chk_eq("R7 hm equal tm flagged", config_error, 1'b1);
    cfg_write(32'h0003_001F);
    chk_eq("R2 dynamic layout", cfg_rdata, 32'h0003_001F);
    chk_eq("R7 dynamic hm 3 legal", config_error, 1'b0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < 32; i++) push(32'hD000_0000 + i);
    chk_eq("R8 no overflow at full", {overflow, fill_level, empty_slots}, {1'b0, 6'd32, 6'd0});
    push(32'hDEAD_BEEF);
    chk_eq("R8 dropped write", {overflow, fill_level}, {1'b1, 6'd32});
    for (int i = 0; i < 32; i++) begin
      pop(d);
      if (i == 0 || i == 31) chk_eq("R8 contents unchanged (R1)", d, 32'hD000_0000 + i);
    end
    chk_eq("R1 drained", fill_level, 6'd0);
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_dynamic();
    t_config_error();
    t_register();
    t_overflow();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end
endmodule